// File: doc/BRIEF.md
# Root Port Status and Change Tracker

This block holds the status and control state of one or more downstream root ports of a host controller. For each port it records whether a device is connected, whether the port is enabled, whether an over-current fault is active, and whether resume signalling is being forced. Every status that can change on its own has a sticky change flag. A flag stays set until software writes a one to its bit position.

Each port cell also produces a one-cycle port-change pulse for the interrupt logic. Hardware events arrive as levels or single-cycle pulses from the line-state and timing logic, which lies outside this block. That logic reports the connect level, a disable due to disconnect or fault, the end of a reset-and-enable sequence, the over-current input, a J-to-K transition seen while the port is suspended, and the end of resume. Port power gates most of the state. While a port is unpowered, its connection and enable fields read as zero.

Software writes one port at a time. It raises that port's write strobe and places a 7-bit word on the shared write data bus. The 7-bit status word has this bit order: 0 connect, 1 connect change, 2 enabled, 3 enable change, 4 over-current active, 5 over-current change, 6 force resume.

Top module: `usb_root_port_tracker`

## Requirements
- R1: During reset every status bit of every port is 0 and no port-change pulse is given.
- R2: Bit 0 (connect) takes the connect level one clock after it is sampled while the port is powered.
- R3: Bit 1 (connect change) is set on every change of bit 0 and stays set while already set. A write with data bit 1 = 1 clears it. A new change in the same cycle as that write keeps it set.
- R4: Bit 2 (enabled) is set only by the reset-complete pulse. A software write with data bit 2 = 1 leaves it unchanged.
- R5: Any write with data bit 2 = 0 clears bit 2 and does not set bit 3.
- R6: The disable-fault pulse clears bit 2. It sets bit 3 (enable change) only when bit 2 was 1. A write with data bit 3 = 1 clears bit 3.
- R7: Bit 4 follows the over-current input one clock later. Bit 5 sets on every change of bit 4 and is cleared by a write with data bit 5 = 1.
- R8: Bit 6 (force resume) is set by a J-to-K detect or by a write with data bit 6 = 1. Only the resume-done pulse clears it. A write with data bit 6 = 0 has no effect on it.
- R9: The port-change output is high for exactly one clock when bit 1, 3 or 5 goes from 0 to 1, or when a J-to-K detect sets bit 6. A software set of bit 6 gives no pulse.
- R10: While port power is 0, bits 0 to 3 read 0 and the reset-complete pulse is ignored. When power returns with a device connected, that counts as a connect change.
- R11: Each port has its own inputs and write strobe. Activity on one port leaves the status and pulse of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_pwr | input | PORTS | Port power, one bit per port |
| conn_lvl | input | PORTS | Connect level, synchronous |
| fault_dis | input | PORTS | Disable pulse due to disconnect or fault |
| rst_done | input | PORTS | Reset-and-enable sequence complete pulse |
| oc_fault | input | PORTS | Over-current input level |
| jk_susp | input | PORTS | J-to-K detected while suspended, pulse |
| resume_done | input | PORTS | Resume sequence finished, pulse |
| wr_en | input | PORTS | Software write strobe, one bit per port |
| wr_data | input | 7 | Software write data shared by all ports |
| status | output | PORTS*7 | Status words, port p at bits 7p+6..7p |
| chg_evt | output | PORTS | One-cycle port-change pulse per port |

## Verification
The case that is hardest to reach is a cell that is powered off while it holds state in several fields at once, followed by a power-up that must be seen as a new connection. The stimulus first builds up a connected, enabled and cleared port. It then drops power while the connect level and a reset-complete pulse are still active, and restores power to check that a single change pulse appears. Races between a hardware set and a software clear of the same change bit, and a fault pulse on a port that is already disabled, are driven in single cycles of their own.

// File: rtl/usb_rpt_pkg.sv
package usb_rpt_pkg;
   localparam int ST_W     = 7;
   localparam int B_CONN   = 0;
   localparam int B_CONN_C = 1;
   localparam int B_ENA    = 2;
   localparam int B_ENA_C  = 3;
   localparam int B_OC     = 4;
   localparam int B_OC_C   = 5;
   localparam int B_RES    = 6;
   localparam int MAX_PORTS = 16;
endpackage

// File: rtl/usb_rpt_flag.sv
module usb_rpt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic kill_i,
   output logic q_o,
   output logic rise_o
);
   logic q_d;

   always_comb begin
      q_d = q_o;
      if (kill_i)      q_d = 1'b0;
      else if (set_i)  q_d = 1'b1;
      else if (clr_i)  q_d = 1'b0;
   end

   assign rise_o = q_d & ~q_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_d;
   end

   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !kill_i) |=> q_o);
endmodule

// File: rtl/usb_rpt_cell.sv
module usb_rpt_cell
   import usb_rpt_pkg::*;
#(
   parameter bit OC_PRESENT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwr_i,
   input  logic            conn_i,
   input  logic            fdis_i,
   input  logic            rdone_i,
   input  logic            oc_i,
   input  logic            jk_i,
   input  logic            rsd_i,
   input  logic            wr_i,
   input  logic [ST_W-1:0] wd_i,
   output logic [ST_W-1:0] st_o,
   output logic            evt_o
);
   logic conn_q, ena_q, oca_q, res_q;
   logic conn_c_q, ena_c_q, oc_c_q;
   logic conn_rise, ena_rise, oc_rise;
   logic oc_chg;
   logic hw_res_rise;
   logic unused_ro_bits;

   assign unused_ro_bits = ^{wd_i[B_CONN], wd_i[B_OC]};

   // connect level, forced to zero while unpowered
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conn_q <= 1'b0;
      else        conn_q <= pwr_i & conn_i;
   end

   usb_rpt_flag u_conn_c (
      .clk(clk), .rst_n(rst_n),
      .set_i (pwr_i & (conn_i ^ conn_q)),
      .clr_i (wr_i & wd_i[B_CONN_C]),
      .kill_i(~pwr_i),
      .q_o(conn_c_q), .rise_o(conn_rise)
   );

   // enable: hardware sets, software or fault clears
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ena_q <= 1'b0;
      else if (!pwr_i)              ena_q <= 1'b0;
      else if (fdis_i)              ena_q <= 1'b0;
      else if (wr_i && !wd_i[B_ENA]) ena_q <= 1'b0;
      else if (rdone_i)             ena_q <= 1'b1;
   end

   usb_rpt_flag u_ena_c (
      .clk(clk), .rst_n(rst_n),
      .set_i (pwr_i & fdis_i & ena_q),
      .clr_i (wr_i & wd_i[B_ENA_C]),
      .kill_i(~pwr_i),
      .q_o(ena_c_q), .rise_o(ena_rise)
   );

   generate
      if (OC_PRESENT) begin : g_oc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oca_q <= 1'b0;
            else        oca_q <= oc_i;
         end
         assign oc_chg = oc_i ^ oca_q;

         a_r7_oc_follow: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (oca_q == $past(oc_i)));
      end else begin : g_no_oc
         logic unused_oc;
         assign unused_oc = oc_i;
         assign oca_q  = 1'b0;
         assign oc_chg = 1'b0;
      end
   endgenerate

   usb_rpt_flag u_oc_c (
      .clk(clk), .rst_n(rst_n),
      .set_i (oc_chg),
      .clr_i (wr_i & wd_i[B_OC_C]),
      .kill_i(1'b0),
      .q_o(oc_c_q), .rise_o(oc_rise)
   );

   // force resume: only the resume-done pulse clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         res_q <= 1'b0;
      else if (rsd_i)                     res_q <= 1'b0;
      else if (jk_i || (wr_i && wd_i[B_RES])) res_q <= 1'b1;
   end

   assign hw_res_rise = jk_i & ~rsd_i & ~res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_o <= 1'b0;
      else        evt_o <= conn_rise | ena_rise | oc_rise | hw_res_rise;
   end

   assign st_o[B_CONN]   = conn_q   & pwr_i;
   assign st_o[B_CONN_C] = conn_c_q & pwr_i;
   assign st_o[B_ENA]    = ena_q    & pwr_i;
   assign st_o[B_ENA_C]  = ena_c_q  & pwr_i;
   assign st_o[B_OC]     = oca_q;
   assign st_o[B_OC_C]   = oc_c_q;
   assign st_o[B_RES]    = res_q;

   a_r4_no_sw_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena_q && !rdone_i) |=> !ena_q);
   a_r6_enc_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ena_c_q) |-> ($past(fdis_i) && $past(ena_q)));
   a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (res_q && !rsd_i) |=> res_q);
   a_r9_evt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(conn_c_q) || $rose(ena_c_q) || $rose(oc_c_q)) |-> evt_o);
   a_r10_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_i |=> (!conn_q && !conn_c_q && !ena_q && !ena_c_q));
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o || $past(conn_rise | ena_rise | oc_rise | hw_res_rise));
endmodule

// File: rtl/usb_root_port_tracker.sv
module usb_root_port_tracker
   import usb_rpt_pkg::*;
#(
   parameter int PORTS      = 2,
   parameter bit OC_PRESENT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PORTS-1:0]      port_pwr,
   input  logic [PORTS-1:0]      conn_lvl,
   input  logic [PORTS-1:0]      fault_dis,
   input  logic [PORTS-1:0]      rst_done,
   input  logic [PORTS-1:0]      oc_fault,
   input  logic [PORTS-1:0]      jk_susp,
   input  logic [PORTS-1:0]      resume_done,
   input  logic [PORTS-1:0]      wr_en,
   input  logic [ST_W-1:0]       wr_data,
   output logic [PORTS*ST_W-1:0] status,
   output logic [PORTS-1:0]      chg_evt
);
   localparam int STAT_W = PORTS * ST_W;

   generate
      if (PORTS < 1 || PORTS > MAX_PORTS) begin : g_bad_ports
         $error("usb_root_port_tracker: PORTS out of range");
      end
      if (STAT_W != $bits(status)) begin : g_bad_width
         $error("usb_root_port_tracker: status width mismatch");
      end
   endgenerate

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         usb_rpt_cell #(.OC_PRESENT(OC_PRESENT)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_i  (port_pwr[p]),
            .conn_i (conn_lvl[p]),
            .fdis_i (fault_dis[p]),
            .rdone_i(rst_done[p]),
            .oc_i   (oc_fault[p]),
            .jk_i   (jk_susp[p]),
            .rsd_i  (resume_done[p]),
            .wr_i   (wr_en[p]),
            .wd_i   (wr_data),
            .st_o   (status[p*ST_W +: ST_W]),
            .evt_o  (chg_evt[p])
         );
      end
   endgenerate

   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (chg_evt == '0) || rst_n);
endmodule

// File: tb/usb_root_port_tracker_test.sv
module usb_root_port_tracker_test;
   localparam int CLK_PERIOD = 10;
   localparam int P = 2;

   typedef struct {
      logic [6:0] s0;
      logic       e0;
      logic [6:0] s1;
      logic       e1;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [P-1:0] port_pwr = '0, conn_lvl = '0, fault_dis = '0, rst_done = '0;
   logic [P-1:0] oc_fault = '0, jk_susp = '0, resume_done = '0, wr_en = '0;
   logic [6:0]   wr_data = '0;
   logic [P*7-1:0] status;
   logic [P-1:0]   chg_evt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_root_port_tracker #(.PORTS(P)) uut (
      .clk(clk), .rst_n(rst_n), .port_pwr(port_pwr), .conn_lvl(conn_lvl),
      .fault_dis(fault_dis), .rst_done(rst_done), .oc_fault(oc_fault),
      .jk_susp(jk_susp), .resume_done(resume_done), .wr_en(wr_en),
      .wr_data(wr_data), .status(status), .chg_evt(chg_evt)
   );

   task automatic chk(input string tag, input string what, input logic [6:0] got, input logic [6:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   // drive port 0 for one cycle; port 1 connect taken from c1
   task automatic step(input logic pp, input logic cn, input logic fd, input logic rd,
                       input logic oc, input logic jk, input logic rs,
                       input logic wr, input logic [6:0] wd,
                       input logic [6:0] s0, input logic e0, input string tag,
                       input logic c1 = 1'b0, input logic [6:0] s1 = 7'h00,
                       input logic e1 = 1'b0);
      exp_t it;
      @(negedge clk);
      port_pwr    = {1'b1, pp};
      conn_lvl    = {c1, cn};
      fault_dis   = {1'b0, fd};
      rst_done    = {1'b0, rd};
      oc_fault    = {1'b0, oc};
      jk_susp     = {1'b0, jk};
      resume_done = {1'b0, rs};
      wr_en       = {1'b0, wr};
      wr_data     = wd;
      it.s0 = s0; it.e0 = e0; it.s1 = s1; it.e1 = e1; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compare after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk(it.tag, "port0 status", status[6:0], it.s0);
            chk(it.tag, "port0 event", {6'd0, chg_evt[0]}, {6'd0, it.e0});
            chk(it.tag, "port1 status", status[13:7], it.s1);
            chk(it.tag, "port1 event", {6'd0, chg_evt[1]}, {6'd0, it.e1});
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset status", status[6:0], 7'h00);
      chk("R1", "reset status p1", status[13:7], 7'h00);
      chk("R1", "reset event", {5'd0, chg_evt}, 7'h00);
      rst_n = 1'b1;
      //   pp cn fd rd oc jk rs wr wd     s0     e0
      step(1, 1, 0, 0, 0, 0, 0, 0, 7'h00, 7'h03, 1, "R2");
      step(1, 1, 0, 0, 0, 0, 0, 0, 7'h00, 7'h03, 0, "R2");
      step(1, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h02, 0, "R3");
      step(1, 1, 0, 0, 0, 0, 0, 0, 7'h00, 7'h03, 0, "R3");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h02, 7'h01, 0, "R3");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h04, 7'h01, 0, "R4");
      step(1, 1, 0, 1, 0, 0, 0, 0, 7'h00, 7'h05, 0, "R4");
      step(1, 1, 1, 0, 0, 0, 0, 0, 7'h00, 7'h09, 1, "R6");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h08, 7'h01, 0, "R6");
      step(1, 1, 0, 1, 0, 0, 0, 0, 7'h00, 7'h05, 0, "R4");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h00, 7'h01, 0, "R5");
      step(1, 1, 1, 0, 0, 0, 0, 0, 7'h00, 7'h01, 0, "R6");
      step(1, 1, 0, 0, 1, 0, 0, 0, 7'h00, 7'h31, 1, "R7");
      step(1, 1, 0, 0, 0, 0, 0, 0, 7'h00, 7'h21, 0, "R7");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h20, 7'h01, 0, "R7");
      step(1, 1, 0, 0, 0, 1, 0, 0, 7'h00, 7'h41, 1, "R9");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h00, 7'h41, 0, "R8");
      step(1, 1, 0, 0, 0, 0, 1, 0, 7'h00, 7'h01, 0, "R8");
      step(1, 1, 0, 0, 0, 0, 0, 1, 7'h40, 7'h41, 0, "R9");
      step(1, 1, 0, 0, 0, 0, 1, 0, 7'h00, 7'h01, 0, "R8");
      step(1, 1, 0, 1, 0, 0, 0, 0, 7'h00, 7'h05, 0, "R4");
      step(0, 1, 0, 0, 0, 0, 0, 0, 7'h00, 7'h00, 0, "R10");
      step(0, 1, 0, 1, 0, 0, 0, 0, 7'h00, 7'h00, 0, "R10");
      step(1, 1, 0, 0, 0, 0, 0, 0, 7'h00, 7'h03, 1, "R10");
      step(1, 0, 0, 0, 0, 0, 0, 1, 7'h02, 7'h02, 0, "R3");
      step(1, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h02, 0, "R11", 1'b1, 7'h03, 1'b1);
      step(1, 0, 0, 0, 0, 0, 0, 0, 7'h00, 7'h02, 0, "R11", 1'b1, 7'h03, 1'b0);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule